// File: doc/BRIEF.md
# Folded symmetric FIR low-pass filter

This block is a streaming linear-phase low-pass FIR filter for an 8-bit converter sample stream. Each accepted sample is converted from offset-binary to two's complement and pushed into a history of the last 17 samples. Because the coefficient set is mirror-symmetric, every pair of samples that shares a coefficient is summed first. Each pair sum is then multiplied once. The 17-tap response therefore needs nine multipliers instead of seventeen.

The datapath is fully pipelined. The stages are: history update, pair fold, multiply, and accumulate with optional rounding. Every strobed input produces exactly one strobed output a fixed four clocks later. Idle cycles between strobes do not disturb the stored history. With the default `OUT_DROP = 0` the output is the exact, full-precision convolution result. A non-zero `OUT_DROP` rounds off that many low bits, with halves rounded upward.

The default coefficients are signed 16-bit integers taken from a Blackman-windowed low-pass design. They are scaled so that the centre tap sits near full scale. Indexed from the newest sample, h(0..8) = 0, 499, 2301, 6003, 11797, 18881, 25467, 29464, 31200, and h(16-k) = h(k).

Top module: `fir_sym_lowpass`

## Requirements
- R1: `in_sample` is offset-binary: code c stands for the value c − 128. Code 0x80 is zero, 0x81 is +1, 0xFF is +127 and 0x00 is −128.
- R2: Each output equals the sum over k = 0..16 of h(k)·x(n−k), using the coefficient table in the description. Here x(n) is the newest accepted sample, and samples before the start of history count as zero. `out_data` carries this sum as an exact 29-bit two's-complement value.
- R3: `out_valid` is high in the clock cycle that follows the fourth rising edge after an edge that samples `in_valid` high. It is high at no other time, so there is exactly one output per input.
- R4: The history advances only on edges where `in_valid` is high. Any number of idle cycles between inputs leaves every later output unchanged.
- R5: While `out_valid` is low, `out_data` keeps the value it had in the previous cycle.
- R6: A synchronous `rst` clears the history and all pipeline stages. In the cycle after reset, `out_valid` and `out_data` are zero. Samples accepted before a reset contribute nothing to outputs after it.
- R7: The magnitude of every output is at most 128 × Σ|h(k)| = 28 163 072.
- R8: A single +1 sample (code 0x81) followed by zero samples produces h(0), h(1), …, h(16) in that order. This sequence is mirror-symmetric about the centre tap.
- R9: A sustained full-scale input reaches the exact extremes without wrap. Code 0x00 settles to −28 163 072, and code 0xFF settles to 127 × 220 024 = 27 943 048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_sample` holds a new sample this cycle |
| in_sample | input | 8 | Offset-binary converter sample |
| out_valid | output | 1 | Strobe: `out_data` holds a new filter result |
| out_data | output | 29 | Filtered sample, two's complement |

## Verification
On every cycle, the bound assertions check four things: the four-clock strobe alignment, that the output holds between strobes, that reset clears the output, and that the output stays within its magnitude bound. The exact arithmetic can only be shown by the bench's reference convolution over its scenarios. These are the +1 impulse tracing the mirrored coefficient sequence, both full-scale steps, random data with random idle gaps, and a reset in the middle of a stream.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

    // Half of the mirrored coefficient table; index m counts from the outer taps.
    function automatic int half_coef(input int m);
        case (m)
            0:       return 0;
            1:       return 499;
            2:       return 2301;
            3:       return 6003;
            4:       return 11797;
            5:       return 18881;
            6:       return 25467;
            7:       return 29464;
            8:       return 31200;
            default: return 0;
        endcase
    endfunction

    // Coefficient for tap k of an n-tap filter, folded onto the mirrored half.
    function automatic int tap_coef(input int k, input int n);
        int m;
        m = (k <= n - 1 - k) ? k : n - 1 - k;
        return half_coef(m);
    endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 17
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           shift_en,
    input  logic [SAMPLE_W-1:0]            din,
    output logic [TAPS-1:0][SAMPLE_W-1:0]  taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int i = 1; i < TAPS; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/fir_fold_stage.sv
module fir_fold_stage #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 17,
    localparam int NPAIR   = TAPS / 2,
    localparam int NMUL    = (TAPS + 1) / 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [TAPS-1:0][SAMPLE_W-1:0]  taps,
    output logic [NMUL-1:0][SAMPLE_W:0]    folded
);

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                folded[i] <= '0;
            end else begin
                folded[i] <= {taps[i][SAMPLE_W-1], taps[i]}
                           + {taps[TAPS-1-i][SAMPLE_W-1], taps[TAPS-1-i]};
            end
        end
    end

    if (TAPS % 2 == 1) begin : g_centre
        always_ff @(posedge clk) begin
            if (rst) begin
                folded[NPAIR] <= '0;
            end else begin
                folded[NPAIR] <= {taps[NPAIR][SAMPLE_W-1], taps[NPAIR]};
            end
        end
    end

endmodule

// File: rtl/fir_mult_stage.sv
module fir_mult_stage #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 16,
    parameter int TAPS     = 17,
    localparam int NMUL    = (TAPS + 1) / 2,
    localparam int PROD_W  = SAMPLE_W + 1 + COEF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NMUL-1:0][SAMPLE_W:0]  folded,
    output logic [NMUL-1:0][PROD_W-1:0]  products
);

    for (genvar i = 0; i < NMUL; i++) begin : g_mul
        localparam logic signed [COEF_W-1:0] COEF = COEF_W'(fir_sym_pkg::tap_coef(i, TAPS));
        always_ff @(posedge clk) begin
            if (rst) begin
                products[i] <= '0;
            end else begin
                products[i] <= PROD_W'($signed(folded[i])) * PROD_W'(COEF);
            end
        end
    end

endmodule

// File: rtl/fir_sum_stage.sv
module fir_sum_stage #(
    parameter int PROD_W   = 25,
    parameter int NMUL     = 9,
    parameter int ACC_W    = 29,
    parameter int OUT_DROP = 0,
    localparam int OUT_W   = ACC_W - OUT_DROP
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [NMUL-1:0][PROD_W-1:0]  products,
    output logic [OUT_W-1:0]             result
);

    logic signed [ACC_W-1:0] acc;
    logic        [OUT_W-1:0] rounded;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NMUL; i++) begin
            acc = acc + ACC_W'($signed(products[i]));
        end
    end

    if (OUT_DROP == 0) begin : g_full
        assign rounded = acc;
    end else begin : g_round
        logic signed [ACC_W-1:0] biased;
        assign biased  = acc + (ACC_W'(1) << (OUT_DROP - 1));
        assign rounded = OUT_W'(biased >>> OUT_DROP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (load) begin
            result <= rounded;
        end
    end

endmodule

// File: rtl/fir_sym_lowpass.sv
module fir_sym_lowpass #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 16,
    parameter int TAPS     = 17,
    parameter int OUT_DROP = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [SAMPLE_W+COEF_W+$clog2(TAPS/2+1)+1-OUT_DROP-1:0] out_data
);

    localparam int NMUL   = (TAPS + 1) / 2;
    localparam int PROD_W = SAMPLE_W + 1 + COEF_W;
    localparam int ACC_W  = SAMPLE_W + COEF_W + $clog2(TAPS / 2 + 1) + 1;

    logic [SAMPLE_W-1:0]           sample_tc;
    logic [TAPS-1:0][SAMPLE_W-1:0] taps;
    logic [NMUL-1:0][SAMPLE_W:0]   folded;
    logic [NMUL-1:0][PROD_W-1:0]   products;
    logic                          v_line, v_fold, v_mult;

    // Offset-binary to two's complement: flip the top bit.
    assign sample_tc = {~in_sample[SAMPLE_W-1], in_sample[SAMPLE_W-2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_line    <= 1'b0;
            v_fold    <= 1'b0;
            v_mult    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_line    <= in_valid;
            v_fold    <= v_line;
            v_mult    <= v_fold;
            out_valid <= v_mult;
        end
    end

    fir_tap_line #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (sample_tc),
        .taps     (taps)
    );

    fir_fold_stage #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_fold (
        .clk    (clk),
        .rst    (rst),
        .taps   (taps),
        .folded (folded)
    );

    fir_mult_stage #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_mult (
        .clk      (clk),
        .rst      (rst),
        .folded   (folded),
        .products (products)
    );

    fir_sum_stage #(.PROD_W(PROD_W), .NMUL(NMUL), .ACC_W(ACC_W), .OUT_DROP(OUT_DROP)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .load     (v_mult),
        .products (products),
        .result   (out_data)
    );

endmodule

// File: rtl/fir_sym_checks.sv
module fir_sym_checks #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 17,
    parameter int OUT_W    = 29,
    parameter int OUT_DROP = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    function automatic longint coef_abs_sum();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) begin
            int c = fir_sym_pkg::tap_coef(k, TAPS);
            s += (c < 0) ? -c : c;
        end
        return s;
    endfunction

    localparam longint BOUND = ((coef_abs_sum() << (SAMPLE_W - 1)) >>> OUT_DROP) + 1;

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R3: output strobe trails the input strobe by exactly four clocks
    a_r3_strobe_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R5: result held between strobes
    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R6: reset clears strobe and result
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R7: magnitude bound
    a_r7_magnitude: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_data)) <= BOUND &&
                       longint'($signed(out_data)) >= -BOUND));

endmodule

bind fir_sym_lowpass fir_sym_checks #(
    .SAMPLE_W (SAMPLE_W),
    .TAPS     (TAPS),
    .OUT_W    (SAMPLE_W + COEF_W + $clog2(TAPS/2+1) + 1 - OUT_DROP),
    .OUT_DROP (OUT_DROP)
) u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_fir_sym_lowpass.sv
module tb_fir_sym_lowpass;

    localparam int N     = 17;
    localparam int OUT_W = 29;
    localparam longint BOUND = 28163072;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_sample = 8'h80;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    always #5 clk = ~clk;

    fir_sym_lowpass dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct { int due; longint val; } exp_t;

    int     checks = 0;
    int     fails  = 0;
    int     cyc    = 0;
    string  tag    = "R2";
    longint hist[$];
    exp_t   pend[$];
    longint last_out = 0;
    bit     done = 0;

    function automatic longint h_of(int k);
        int m;
        m = (k <= 16 - k) ? k : 16 - k;
        case (m)
            0: return 0;      1: return 499;    2: return 2301;
            3: return 6003;   4: return 11797;  5: return 18881;
            6: return 25467;  7: return 29464;  8: return 31200;
            default: return 0;
        endcase
    endfunction

    function automatic longint model_out();
        longint s = 0;
        for (int k = 0; k < hist.size(); k++) s += h_of(k) * hist[k];
        return s;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(bit v, logic [7:0] d, bit r = 1'b0);
        longint got;
        bit     due;
        @(negedge clk);
        cyc++;
        if (!rst) begin
            got = longint'($signed(out_data));
            due = (pend.size() > 0) && (pend[0].due == cyc);
            check(out_valid == due, "R3", longint'(out_valid), longint'(due));
            if (due && out_valid) begin
                check(got == pend[0].val, tag, got, pend[0].val);
                check(got <= BOUND && got >= -BOUND, "R7", got, BOUND);
                last_out = pend[0].val;
            end else if (!out_valid) begin
                check(got == last_out, "R5", got, last_out);
            end
            if (due) void'(pend.pop_front());
        end
        rst       = r;
        in_valid  = v;
        in_sample = d;
        if (r) begin
            hist.delete();
            pend.delete();
            last_out = 0;
        end else if (v) begin
            hist.push_front(longint'(d) - 128);
            if (hist.size() > N) void'(hist.pop_back());
            pend.push_back('{cyc + 4, model_out()});
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) step(1'b0, 8'h80);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R6: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 8'h80, 1'b1);
        step(1'b0, 8'h80);
        @(negedge clk);
        check(out_valid == 1'b0, "R6", longint'(out_valid), 0);
        check(out_data == '0, "R6", longint'($signed(out_data)), 0);

        // R8 / R1: +1 impulse traces the mirrored coefficient list
        tag = "R8";
        step(1'b1, 8'h81);
        for (int i = 0; i < 20; i++) step(1'b1, 8'h80);
        drain();

        // R9: full-scale negative and positive steps
        tag = "R9";
        for (int i = 0; i < 24; i++) step(1'b1, 8'h00);
        drain();
        check(last_out == -28163072, "R9", last_out, -28163072);
        for (int i = 0; i < 24; i++) step(1'b1, 8'hFF);
        drain();
        check(last_out == 27943048, "R9", last_out, 27943048);

        // R1: code 0x80 is zero; history of zeros gives zero
        tag = "R1";
        for (int i = 0; i < 20; i++) step(1'b1, 8'h80);
        drain();
        check(last_out == 0, "R1", last_out, 0);

        // R2 / R3: random data, strobe every cycle
        tag = "R2";
        for (int i = 0; i < 60; i++) step(1'b1, 8'($urandom_range(255)));
        drain();

        // R4: random data with random idle gaps
        tag = "R4";
        for (int i = 0; i < 200; i++) begin
            step(($urandom_range(9) < 5) ? 1'b1 : 1'b0, 8'($urandom_range(255)));
        end
        drain();

        // R6: reset mid-stream discards history
        tag = "R6";
        for (int i = 0; i < 10; i++) step(1'b1, 8'hF0);
        step(1'b0, 8'h80, 1'b1);
        step(1'b0, 8'h80, 1'b1);
        step(1'b0, 8'h80);
        step(1'b1, 8'h81);
        for (int i = 0; i < 18; i++) step(1'b1, 8'h80);
        drain();

        done = 1;
        summary();
        $finish;
    end

endmodule